// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the state transfer that a 32-bit processor with 16-bit instructions makes when it takes an exception, a trap or an interrupt. The core presents single-cycle request pulses: a general fault with a 12-bit cause code, a translation miss with its own cause code, an illegal-instruction event, a trap with an 8-bit immediate, and an interrupt acceptance carrying the code from the interrupt controller. Along with these it supplies its current architectural context: program counter, delay-slot flag, stack register R15, status word and vector base.

On the clock edge that follows a request, the block commits the whole entry at once. It saves the return context, records the cause, and computes the handler address and the following fetch address. It also produces the privileged status word and raises a one-cycle completion pulse. Where the request carries a fault and the vector base is still zero, the block raises a halt pulse instead and changes no register.

Top module: `exc_entry_seq`

## Requirements
- R1: While rst_n is low, every output is zero.
- R2: A general fault request, taken alone, sets cause_out to its code and handler_pc to vec_base + 0x100.
- R3: A translation-miss request sets cause_out to its code and handler_pc to vec_base + 0x400.
- R4: An interrupt acceptance sets irq_cause_out to its code and handler_pc to vec_base + 0x600. It leaves cause_out unchanged, and it saves cur_pc unrewound with slot_clear low, even when in_slot is high.
- R5: Every entry copies cur_sr to saved_sr, cur_r15 to saved_r15, and the (possibly rewound) return address to saved_pc.
- R6: On every entry, fetch_next equals handler_pc + 2.
- R7: entry_sr equals cur_sr with bits 30, 29 and 28 forced to 1. These are the privileged-mode, register-bank and block-interrupt bits.
- R8: A fault, trap or illegal event taken while in_slot is high saves cur_pc - 2 and pulses slot_clear for one cycle.
- R9: A trap sets trap_val to its immediate shifted left by 2, sets cause_out to 0x160, and vectors to vec_base + 0x100.
- R10: An illegal event records cause 0x1A0 when in_slot is high and 0x180 otherwise, and vectors to vec_base + 0x100.
- R11: A fault, trap or illegal entry with vec_base equal to zero pulses halt for one cycle. It updates no output register and gives no entry_done. An interrupt entry is not affected by this rule.
- R12: When several requests coincide, exactly one is taken, in the order translation miss, general fault, illegal, trap, interrupt.
- R13: entry_done pulses for exactly the cycle after a taken request, which is the same cycle in which the new register values appear. Without a request, all registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_req | input | 1 | General fault pulse |
| fault_code | input | 12 | General fault cause code |
| miss_req | input | 1 | Translation-miss pulse |
| miss_code | input | 12 | Translation-miss cause code |
| illegal_req | input | 1 | Illegal-instruction pulse |
| trap_req | input | 1 | Trap pulse |
| trap_imm | input | 8 | Trap immediate |
| irq_req | input | 1 | Interrupt acceptance pulse |
| irq_code | input | 12 | Accepted interrupt code |
| cur_pc | input | 32 | Current program counter |
| in_slot | input | 1 | Current instruction sits in a delay slot |
| cur_r15 | input | 32 | Current R15 |
| cur_sr | input | 32 | Current status word |
| vec_base | input | 32 | Vector base |
| saved_pc | output | 32 | Saved return address |
| saved_sr | output | 32 | Saved status word |
| saved_r15 | output | 32 | Saved R15 |
| cause_out | output | 12 | Fault cause register |
| irq_cause_out | output | 12 | Interrupt cause register |
| trap_val | output | 32 | Trap record register |
| handler_pc | output | 32 | New program counter |
| fetch_next | output | 32 | Next fetch address |
| entry_sr | output | 32 | New status word |
| slot_clear | output | 1 | Delay-slot flag clear pulse |
| entry_done | output | 1 | Entry committed pulse |
| halt | output | 1 | Uninitialised vector base halt pulse |

## Verification
The assertions check four things on every cycle. The next fetch address always trails the handler address by one instruction. The entry status always carries the three privileged bits. The saved status and the unrewound interrupt return address match the inputs one cycle earlier. Halt is tied to a zero vector base and never coincides with completion. The bench scenarios are needed for the rest: choosing among coinciding requests, the choice between the two illegal codes, the trap record, the delay-slot rewind, and the fact that a halted fault leaves every register untouched. For these, a behavioural model of the requirements is compared against all outputs on each clock.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned CODE_W = 12;
  localparam int unsigned IMM_W  = 8;

  typedef enum logic [2:0] {
    CLS_NONE = 3'd0,
    CLS_MISS = 3'd1,
    CLS_FLT  = 3'd2,
    CLS_ILL  = 3'd3,
    CLS_TRAP = 3'd4,
    CLS_IRQ  = 3'd5
  } entry_cls_e;

  // handler address from base and class offset
  function automatic logic [XLEN-1:0] f_vector(input logic [XLEN-1:0] base,
                                               input logic [XLEN-1:0] ofs);
    return base + ofs;
  endfunction

  // return address, rewound by one instruction when required
  function automatic logic [XLEN-1:0] f_return_pc(input logic [XLEN-1:0] pc,
                                                  input logic rewind,
                                                  input logic [XLEN-1:0] step);
    return rewind ? (pc - step) : pc;
  endfunction

  // status word with the three privileged bits forced high
  function automatic logic [XLEN-1:0] f_entry_sr(input logic [XLEN-1:0] sr,
                                                 input int unsigned b_md,
                                                 input int unsigned b_rb,
                                                 input int unsigned b_bl);
    logic [XLEN-1:0] r;
    r = sr;
    r[b_md] = 1'b1;
    r[b_rb] = 1'b1;
    r[b_bl] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  logic       miss_req,
  input  logic       fault_req,
  input  logic       illegal_req,
  input  logic       trap_req,
  input  logic       irq_req,
  input  logic       vbr_zero,
  output entry_cls_e cls,
  output logic       take_exc,
  output logic       take_irq,
  output logic       halt_evt
);
  logic any_exc;

  always_comb begin
    if (miss_req)         cls = CLS_MISS;
    else if (fault_req)   cls = CLS_FLT;
    else if (illegal_req) cls = CLS_ILL;
    else if (trap_req)    cls = CLS_TRAP;
    else if (irq_req)     cls = CLS_IRQ;
    else                  cls = CLS_NONE;
  end

  assign any_exc  = (cls != CLS_NONE) && (cls != CLS_IRQ);
  assign take_exc = any_exc && !vbr_zero;
  assign halt_evt = any_exc && vbr_zero;
  assign take_irq = (cls == CLS_IRQ);
endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
  import exc_entry_pkg::*;
#(
  parameter logic [XLEN-1:0]   OFS_FLT    = 32'h100,
  parameter logic [XLEN-1:0]   OFS_MISS   = 32'h400,
  parameter logic [XLEN-1:0]   OFS_IRQ    = 32'h600,
  parameter logic [CODE_W-1:0] CODE_TRAP  = 12'h160,
  parameter logic [CODE_W-1:0] CODE_ILL   = 12'h180,
  parameter logic [CODE_W-1:0] CODE_SILL  = 12'h1A0,
  parameter int unsigned       INSN_BYTES = 2,
  parameter int unsigned       BIT_MD     = 30,
  parameter int unsigned       BIT_RB     = 29,
  parameter int unsigned       BIT_BL     = 28
) (
  input  entry_cls_e        cls,
  input  logic [CODE_W-1:0] fault_code,
  input  logic [CODE_W-1:0] miss_code,
  input  logic [IMM_W-1:0]  trap_imm,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              in_slot,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   vec_base,
  output logic [XLEN-1:0]   vec_pc,
  output logic [XLEN-1:0]   nxt_pc,
  output logic [XLEN-1:0]   ret_pc,
  output logic [XLEN-1:0]   ent_sr,
  output logic [CODE_W-1:0] exc_code,
  output logic [XLEN-1:0]   trap_rec,
  output logic              rewind
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);
  logic [XLEN-1:0] ofs;

  always_comb begin
    unique case (cls)
      CLS_MISS: begin ofs = OFS_MISS; exc_code = miss_code; end
      CLS_FLT:  begin ofs = OFS_FLT;  exc_code = fault_code; end
      CLS_ILL:  begin ofs = OFS_FLT;  exc_code = in_slot ? CODE_SILL : CODE_ILL; end
      CLS_TRAP: begin ofs = OFS_FLT;  exc_code = CODE_TRAP; end
      CLS_IRQ:  begin ofs = OFS_IRQ;  exc_code = '0; end
      default:  begin ofs = '0;       exc_code = '0; end
    endcase
  end

  assign rewind   = in_slot && (cls != CLS_IRQ) && (cls != CLS_NONE);
  assign vec_pc   = f_vector(vec_base, ofs);
  assign nxt_pc   = vec_pc + STEP;
  assign ret_pc   = f_return_pc(cur_pc, rewind, STEP);
  assign ent_sr   = f_entry_sr(cur_sr, BIT_MD, BIT_RB, BIT_BL);
  assign trap_rec = {{(XLEN-IMM_W-2){1'b0}}, trap_imm, 2'b00};
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_exc,
  input  logic              take_irq,
  input  logic              halt_evt,
  input  logic              is_trap,
  input  logic              rewind,
  input  logic [XLEN-1:0]   vec_pc,
  input  logic [XLEN-1:0]   nxt_pc,
  input  logic [XLEN-1:0]   ret_pc,
  input  logic [XLEN-1:0]   ent_sr,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   cur_r15,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [CODE_W-1:0] irq_code,
  input  logic [XLEN-1:0]   trap_rec,
  output logic [XLEN-1:0]   saved_pc,
  output logic [XLEN-1:0]   saved_sr,
  output logic [XLEN-1:0]   saved_r15,
  output logic [CODE_W-1:0] cause_out,
  output logic [CODE_W-1:0] irq_cause_out,
  output logic [XLEN-1:0]   trap_val,
  output logic [XLEN-1:0]   handler_pc,
  output logic [XLEN-1:0]   fetch_next,
  output logic [XLEN-1:0]   entry_sr,
  output logic              slot_clear,
  output logic              entry_done,
  output logic              halt
);
  logic take;
  assign take = take_exc || take_irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      saved_pc      <= '0;
      saved_sr      <= '0;
      saved_r15     <= '0;
      cause_out     <= '0;
      irq_cause_out <= '0;
      trap_val      <= '0;
      handler_pc    <= '0;
      fetch_next    <= '0;
      entry_sr      <= '0;
      slot_clear    <= 1'b0;
      entry_done    <= 1'b0;
      halt          <= 1'b0;
    end else begin
      entry_done <= take;
      halt       <= halt_evt;
      slot_clear <= take_exc && rewind;
      if (take) begin
        saved_pc   <= ret_pc;
        saved_sr   <= cur_sr;
        saved_r15  <= cur_r15;
        handler_pc <= vec_pc;
        fetch_next <= nxt_pc;
        entry_sr   <= ent_sr;
      end
      if (take_exc) cause_out <= exc_code;
      if (take_irq) irq_cause_out <= irq_code;
      if (take_exc && is_trap) trap_val <= trap_rec;
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter logic [XLEN-1:0]   OFS_FLT    = 32'h100,
  parameter logic [XLEN-1:0]   OFS_MISS   = 32'h400,
  parameter logic [XLEN-1:0]   OFS_IRQ    = 32'h600,
  parameter logic [CODE_W-1:0] CODE_TRAP  = 12'h160,
  parameter logic [CODE_W-1:0] CODE_ILL   = 12'h180,
  parameter logic [CODE_W-1:0] CODE_SILL  = 12'h1A0,
  parameter int unsigned       INSN_BYTES = 2,
  parameter int unsigned       BIT_MD     = 30,
  parameter int unsigned       BIT_RB     = 29,
  parameter int unsigned       BIT_BL     = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_req,
  input  logic [CODE_W-1:0] fault_code,
  input  logic              miss_req,
  input  logic [CODE_W-1:0] miss_code,
  input  logic              illegal_req,
  input  logic              trap_req,
  input  logic [IMM_W-1:0]  trap_imm,
  input  logic              irq_req,
  input  logic [CODE_W-1:0] irq_code,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              in_slot,
  input  logic [XLEN-1:0]   cur_r15,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   vec_base,
  output logic [XLEN-1:0]   saved_pc,
  output logic [XLEN-1:0]   saved_sr,
  output logic [XLEN-1:0]   saved_r15,
  output logic [CODE_W-1:0] cause_out,
  output logic [CODE_W-1:0] irq_cause_out,
  output logic [XLEN-1:0]   trap_val,
  output logic [XLEN-1:0]   handler_pc,
  output logic [XLEN-1:0]   fetch_next,
  output logic [XLEN-1:0]   entry_sr,
  output logic              slot_clear,
  output logic              entry_done,
  output logic              halt
);
  // named internal events
  entry_cls_e        ev_cls;
  logic              ev_take_exc;
  logic              ev_take_irq;
  logic              ev_halt;
  logic              ev_rewind;
  logic [XLEN-1:0]   w_vec_pc;
  logic [XLEN-1:0]   w_nxt_pc;
  logic [XLEN-1:0]   w_ret_pc;
  logic [XLEN-1:0]   w_ent_sr;
  logic [CODE_W-1:0] w_exc_code;
  logic [XLEN-1:0]   w_trap_rec;

  exc_arbiter u_arb (
    .miss_req    (miss_req),
    .fault_req   (fault_req),
    .illegal_req (illegal_req),
    .trap_req    (trap_req),
    .irq_req     (irq_req),
    .vbr_zero    (vec_base == '0),
    .cls         (ev_cls),
    .take_exc    (ev_take_exc),
    .take_irq    (ev_take_irq),
    .halt_evt    (ev_halt)
  );

  exc_vector_calc #(
    .OFS_FLT(OFS_FLT), .OFS_MISS(OFS_MISS), .OFS_IRQ(OFS_IRQ),
    .CODE_TRAP(CODE_TRAP), .CODE_ILL(CODE_ILL), .CODE_SILL(CODE_SILL),
    .INSN_BYTES(INSN_BYTES), .BIT_MD(BIT_MD), .BIT_RB(BIT_RB), .BIT_BL(BIT_BL)
  ) u_calc (
    .cls        (ev_cls),
    .fault_code (fault_code),
    .miss_code  (miss_code),
    .trap_imm   (trap_imm),
    .cur_pc     (cur_pc),
    .in_slot    (in_slot),
    .cur_sr     (cur_sr),
    .vec_base   (vec_base),
    .vec_pc     (w_vec_pc),
    .nxt_pc     (w_nxt_pc),
    .ret_pc     (w_ret_pc),
    .ent_sr     (w_ent_sr),
    .exc_code   (w_exc_code),
    .trap_rec   (w_trap_rec),
    .rewind     (ev_rewind)
  );

  exc_state_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .take_exc      (ev_take_exc),
    .take_irq      (ev_take_irq),
    .halt_evt      (ev_halt),
    .is_trap       (ev_cls == CLS_TRAP),
    .rewind        (ev_rewind),
    .vec_pc        (w_vec_pc),
    .nxt_pc        (w_nxt_pc),
    .ret_pc        (w_ret_pc),
    .ent_sr        (w_ent_sr),
    .cur_sr        (cur_sr),
    .cur_r15       (cur_r15),
    .exc_code      (w_exc_code),
    .irq_code      (irq_code),
    .trap_rec      (w_trap_rec),
    .saved_pc      (saved_pc),
    .saved_sr      (saved_sr),
    .saved_r15     (saved_r15),
    .cause_out     (cause_out),
    .irq_cause_out (irq_cause_out),
    .trap_val      (trap_val),
    .handler_pc    (handler_pc),
    .fetch_next    (fetch_next),
    .entry_sr      (entry_sr),
    .slot_clear    (slot_clear),
    .entry_done    (entry_done),
    .halt          (halt)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int unsigned INSN_BYTES = 2,
  parameter int unsigned BIT_MD     = 30,
  parameter int unsigned BIT_RB     = 29,
  parameter int unsigned BIT_BL     = 28
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_take_exc,
  input logic            ev_take_irq,
  input logic [XLEN-1:0] cur_pc,
  input logic [XLEN-1:0] cur_sr,
  input logic [XLEN-1:0] vec_base,
  input logic [XLEN-1:0] saved_pc,
  input logic [XLEN-1:0] saved_sr,
  input logic [XLEN-1:0] handler_pc,
  input logic [XLEN-1:0] fetch_next,
  input logic [XLEN-1:0] entry_sr,
  input logic            slot_clear,
  input logic            entry_done,
  input logic            halt
);
  p_next_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> fetch_next == handler_pc + XLEN'(INSN_BYTES));

  p_priv_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> (entry_sr[BIT_MD] && entry_sr[BIT_RB] && entry_sr[BIT_BL]));

  p_sr_saved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_take_exc || ev_take_irq) |=> saved_sr == $past(cur_sr));

  p_irq_no_rewind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take_irq |=> (saved_pc == $past(cur_pc)) && !slot_clear);

  p_halt_base_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take_exc |-> vec_base != '0);

  p_halt_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(entry_done && halt));
endmodule

bind exc_entry_seq exc_entry_chk #(
  .INSN_BYTES(INSN_BYTES), .BIT_MD(BIT_MD), .BIT_RB(BIT_RB), .BIT_BL(BIT_BL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_take_exc(ev_take_exc), .ev_take_irq(ev_take_irq),
  .cur_pc(cur_pc), .cur_sr(cur_sr), .vec_base(vec_base), .saved_pc(saved_pc),
  .saved_sr(saved_sr), .handler_pc(handler_pc), .fetch_next(fetch_next),
  .entry_sr(entry_sr), .slot_clear(slot_clear), .entry_done(entry_done), .halt(halt)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fault_req = 0, miss_req = 0, illegal_req = 0, trap_req = 0, irq_req = 0;
  logic [11:0] fault_code = '0, miss_code = '0, irq_code = '0;
  logic [7:0]  trap_imm = '0;
  logic [31:0] cur_pc = '0, cur_r15 = '0, cur_sr = '0, vec_base = '0;
  logic in_slot = 1'b0;

  logic [31:0] saved_pc, saved_sr, saved_r15, trap_val, handler_pc, fetch_next, entry_sr;
  logic [11:0] cause_out, irq_cause_out;
  logic slot_clear, entry_done, halt;

  // model state
  logic [31:0] m_spc, m_ssr, m_sgr, m_tra, m_hpc, m_npc, m_nsr;
  logic [11:0] m_exc, m_int;
  logic m_slot, m_done, m_halt, m_inrst;

  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst_n(rst_n),
    .fault_req(fault_req), .fault_code(fault_code),
    .miss_req(miss_req), .miss_code(miss_code),
    .illegal_req(illegal_req), .trap_req(trap_req), .trap_imm(trap_imm),
    .irq_req(irq_req), .irq_code(irq_code),
    .cur_pc(cur_pc), .in_slot(in_slot), .cur_r15(cur_r15), .cur_sr(cur_sr),
    .vec_base(vec_base),
    .saved_pc(saved_pc), .saved_sr(saved_sr), .saved_r15(saved_r15),
    .cause_out(cause_out), .irq_cause_out(irq_cause_out), .trap_val(trap_val),
    .handler_pc(handler_pc), .fetch_next(fetch_next), .entry_sr(entry_sr),
    .slot_clear(slot_clear), .entry_done(entry_done), .halt(halt)
  );

  // behavioural reference model, stepped on each rising edge
  always @(posedge clk) begin
    integer kind;  // 0 none, 1 fault-class, 2 interrupt
    integer ofs;
    logic [11:0] code;
    m_done = 0; m_halt = 0; m_slot = 0;
    m_inrst = !rst_n;
    if (!rst_n) begin
      m_spc = 0; m_ssr = 0; m_sgr = 0; m_tra = 0; m_hpc = 0; m_npc = 0;
      m_nsr = 0; m_exc = 0; m_int = 0;
    end else begin
      kind = 0; ofs = 0; code = 0;
      // R12 order
      if (miss_req)         begin kind = 1; ofs = 'h400; code = miss_code; end
      else if (fault_req)   begin kind = 1; ofs = 'h100; code = fault_code; end
      else if (illegal_req) begin kind = 1; ofs = 'h100; code = in_slot ? 12'h1A0 : 12'h180; end
      else if (trap_req)    begin kind = 3; ofs = 'h100; code = 12'h160; end
      else if (irq_req)     begin kind = 2; ofs = 'h600; end
      if ((kind == 1 || kind == 3) && vec_base == 0) begin
        m_halt = 1;
      end else if (kind != 0) begin
        m_done = 1;
        m_ssr = cur_sr; m_sgr = cur_r15;
        m_hpc = vec_base + ofs;
        m_npc = m_hpc + 2;
        m_nsr = cur_sr | 32'h7000_0000;
        if (kind == 2) begin
          m_int = irq_code; m_spc = cur_pc;
        end else begin
          m_exc = code;
          m_spc = in_slot ? cur_pc - 2 : cur_pc;
          m_slot = in_slot;
          if (kind == 3) m_tra = {22'd0, trap_imm, 2'b00};
        end
      end
    end
  end

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // compare every output at each falling edge
  always @(negedge clk) begin
    cycles++;
    if (cycles > 1) begin
      if (m_inrst) begin
        cmp("R1 reset outputs", {saved_pc ^ saved_sr ^ saved_r15 ^ trap_val ^ handler_pc ^ fetch_next ^ entry_sr},
            32'd0);
        cmp("R1 reset flags", {8'd0, cause_out, irq_cause_out, 5'd0, slot_clear, entry_done, halt}, 32'd0);
      end else begin
        cmp("R5 saved_pc", saved_pc, m_spc);
        cmp("R5 saved_sr", saved_sr, m_ssr);
        cmp("R5 saved_r15", saved_r15, m_sgr);
        cmp("R2/R3/R10 cause_out", 32'(cause_out), 32'(m_exc));
        cmp("R4 irq_cause_out", 32'(irq_cause_out), 32'(m_int));
        cmp("R9 trap_val", trap_val, m_tra);
        cmp("R2/R3/R4 handler_pc", handler_pc, m_hpc);
        cmp("R6 fetch_next", fetch_next, m_npc);
        cmp("R7 entry_sr", entry_sr, m_nsr);
        cmp("R8 slot_clear", 32'(slot_clear), 32'(m_slot));
        cmp("R13 entry_done", 32'(entry_done), 32'(m_done));
        cmp("R11 halt", 32'(halt), 32'(m_halt));
      end
    end
    if (cycles > WATCHDOG) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic ctx(input logic [31:0] pc, input logic slot, input logic [31:0] sr,
                     input logic [31:0] r15, input logic [31:0] vb);
    cur_pc = pc; in_slot = slot; cur_sr = sr; cur_r15 = r15; vec_base = vb;
  endtask

  task automatic pulse(input logic f, input logic m, input logic il, input logic t,
                       input logic i);
    fault_req = f; miss_req = m; illegal_req = il; trap_req = t; irq_req = i;
    @(negedge clk);
    fault_req = 0; miss_req = 0; illegal_req = 0; trap_req = 0; irq_req = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 general fault, not in slot
    ctx(32'h8C00_1000, 0, 32'h0000_00F1, 32'h8C0F_FFF0, 32'h8C00_0000);
    fault_code = 12'h0E0;
    pulse(1, 0, 0, 0, 0);
    // R3 translation miss in slot, R8 rewind
    ctx(32'h8C00_2002, 1, 32'h4000_0003, 32'h1234_5678, 32'h8000_0000);
    miss_code = 12'h040;
    pulse(0, 1, 0, 0, 0);
    // R4 interrupt in slot: no rewind
    ctx(32'h8C00_3004, 1, 32'h0000_0000, 32'hAAAA_5555, 32'h8C00_0000);
    irq_code = 12'h320;
    pulse(0, 0, 0, 0, 1);
    // R9 trap with high immediate
    ctx(32'h0000_0010, 0, 32'h1000_0000, 32'h0000_0001, 32'hFFFF_FF00);
    trap_imm = 8'hFF;
    pulse(0, 0, 0, 1, 0);
    // R10 illegal, normal and slot
    ctx(32'h0000_2000, 0, 32'h0, 32'h0, 32'h0000_4000);
    pulse(0, 0, 1, 0, 0);
    ctx(32'h0000_2000, 1, 32'h0, 32'h0, 32'h0000_4000);
    pulse(0, 0, 1, 0, 0);
    // R11 zero base: fault, trap, illegal halt; interrupt still enters
    ctx(32'h0000_5000, 1, 32'h0, 32'h9, 32'h0);
    trap_imm = 8'h11;
    pulse(1, 0, 0, 0, 0);
    pulse(0, 0, 0, 1, 0);
    pulse(0, 0, 1, 0, 0);
    irq_code = 12'h3A0;
    pulse(0, 0, 0, 0, 1);
    // R12 coinciding requests
    ctx(32'h8C00_6000, 0, 32'h0000_0700, 32'h77, 32'h8C00_0000);
    fault_code = 12'h1E0; miss_code = 12'h060; trap_imm = 8'h22; irq_code = 12'h200;
    pulse(1, 1, 1, 1, 1);
    pulse(1, 0, 1, 1, 1);
    pulse(0, 0, 1, 1, 1);
    pulse(0, 0, 0, 1, 1);
    // R13 back-to-back pulses on consecutive cycles
    fault_req = 1; @(negedge clk);
    fault_req = 0; irq_req = 1; @(negedge clk);
    irq_req = 0;
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule